// File: doc/BRIEF.md
# Periodic Interval Timer Bank

This block holds a set of interval timers that share one simple memory-mapped register port. There is one timer slot for each processor and one slot for the whole system. Each slot has a counter and a limit. A single-cycle tick-enable input, pulsed once per microsecond by an external prescaler, advances every counter at the same time. When a counter reaches a non-zero limit, the slot latches an interrupt and the counter starts again from 1.

The system slot drives the level-10 interrupt line. Each processor slot drives its own level-14 line. Software programs the period by writing the limit. It acknowledges an interrupt by reading the limit back. Both the limit and the count sit in the upper field of the data word, above a fixed number of zero bits.

Top module: `interval_timer_array`

## Requirements
- R1: After reset every interrupt output is low, every limit reads as zero and every count reads as 1 (shifted into the field).
- R2: The counter advances by exactly one on each cycle where `tick` is high and holds otherwise. Register values occupy bits DATA_W-1:FIELD_LSB (31:10 by default), and bits below FIELD_LSB always read as zero.
- R3: When `tick` is high, the limit is non-zero and the count equals the limit, the slot's interrupt is high from the next cycle and the count becomes 1. A limit of L therefore produces one hit every L ticks.
- R4: A read of a slot's limit register returns the stored limit and clears that slot's interrupt from the next cycle.
- R5: Once set, an interrupt stays high until its limit is read or written. Further hits before that leave it high and only reload the counter.
- R6: A write to a limit register loads bits DATA_W-1:FIELD_LSB of `wdata` as the limit, sets the count to 1 and clears the interrupt. The write wins over a tick in the same cycle.
- R7: A slot whose limit is zero never raises its interrupt, but its counter keeps advancing on ticks.
- R8: Slots 0 to NCPU-1 drive `irqL14[slot]`, and slot NCPU drives `irqL10`.
- R9: Word address bit 0 selects the register within a slot (0 = limit, 1 = count), and the bits above it give the slot number. Accesses to slot numbers above NCPU are ignored and read as zero. Writes to a count register are ignored.
- R10: If a hit and a limit read land in the same cycle, the interrupt stays high.
- R11: When `wr` and `rd` are both high, only the write takes effect and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count-enable pulse (one microsecond) |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe |
| addr | input | $clog2(NCPU+1)+1 | Word address: {slot, register select} |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational, zero when not reading |
| irqL10 | output | 1 | System timer interrupt |
| irqL14 | output | NCPU | Per-processor timer interrupts |

## Verification
The bench builds the block with NCPU=4, DATA_W=32 and FIELD_LSB=10. This gives five slots and a 4-bit address, so slot numbers 5 to 7 exist on the port and exercise the ignore path. Limits are kept to 1 to 5 ticks, so hits, repeated hits while an interrupt is pending, and hits that coincide with reads or writes all occur often in a few thousand cycles. The 22-bit wrap of a zero-limit counter lies out of reach at these run lengths.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // widest slot number the strobe bundle can carry
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             tick;   // advance all counters
    logic             limWr;  // write limit of slot idx
    logic             limRd;  // read (and acknowledge) limit of slot idx
    logic             cntRd;  // read count of slot idx
    logic [IDX_W-1:0] idx;    // addressed slot
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_slice.sv
module tmr_slice #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ldEn,
  input  logic             rdAck,
  input  logic [CNT_W-1:0] ldVal,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit,
  output logic             irq
);
  logic hit;

  assign hit = tick && (limit != '0) && (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= CNT_W'(1);
      limit <= '0;
      irq   <= 1'b0;
    end else if (ldEn) begin
      limit <= ldVal;
      count <= CNT_W'(1);
      irq   <= 1'b0;
    end else begin
      if (tick) count <= hit ? CNT_W'(1) : count + 1'b1;
      if (hit) irq <= 1'b1;
      else if (rdAck) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NCPU = 4,
  localparam int NT = NCPU + 1,
  localparam int ADDR_W = $clog2(NT) + 1
) (
  input  logic              tick,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output tmrStrobe_t        strb
);
  logic [ADDR_W-2:0] slot;
  logic              slotOk;
  logic              rdOnly;

  always_comb begin
    slot   = addr[ADDR_W-1:1];
    slotOk = int'(slot) < NT;
    rdOnly = rd && !wr;
    strb.tick  = tick;
    strb.idx   = IDX_W'(slot);
    strb.limWr = wr && slotOk && !addr[0];
    strb.limRd = rdOnly && slotOk && !addr[0];
    strb.cntRd = rdOnly && slotOk && addr[0];
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DATA_W = 32,
  parameter int FIELD_LSB = 10,
  localparam int NT = NCPU + 1,
  localparam int CNT_W = DATA_W - FIELD_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmrStrobe_t        strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [NT-1:0]     irqVec,
  output logic [DATA_W-1:0] rdata
);
  logic [CNT_W-1:0] cntArr [NT];
  logic [CNT_W-1:0] limArr [NT];

  for (genvar i = 0; i < NT; i++) begin : g_slot
    logic hitSel;
    assign hitSel = (strb.idx == IDX_W'(i));
    tmr_slice #(.CNT_W(CNT_W)) u_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (strb.tick),
      .ldEn  (strb.limWr && hitSel),
      .rdAck (strb.limRd && hitSel),
      .ldVal (wdata[DATA_W-1:FIELD_LSB]),
      .count (cntArr[i]),
      .limit (limArr[i]),
      .irq   (irqVec[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NT; k++) begin
      if (strb.idx == IDX_W'(k)) begin
        if (strb.limRd) rdata = {limArr[k], {FIELD_LSB{1'b0}}};
        if (strb.cntRd) rdata = {cntArr[k], {FIELD_LSB{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/interval_timer_array.sv
module interval_timer_array
  import tmr_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DATA_W = 32,
  parameter int FIELD_LSB = 10,
  localparam int ADDR_W = $clog2(NCPU + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irqL10,
  output logic [NCPU-1:0]   irqL14
);
  tmrStrobe_t    strb;
  logic [NCPU:0] irqVec;

  tmr_ctrl #(.NCPU(NCPU)) u_ctrl (
    .tick (tick),
    .wr   (wr),
    .rd   (rd),
    .addr (addr),
    .strb (strb)
  );

  tmr_datapath #(.NCPU(NCPU), .DATA_W(DATA_W), .FIELD_LSB(FIELD_LSB)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .wdata  (wdata),
    .irqVec (irqVec),
    .rdata  (rdata)
  );

  assign irqL14 = irqVec[NCPU-1:0];
  assign irqL10 = irqVec[NCPU];
endmodule

// File: rtl/interval_timer_array_chk.sv
module interval_timer_array_chk #(
  parameter int NCPU = 4,
  parameter int DATA_W = 32,
  parameter int FIELD_LSB = 10,
  localparam int ADDR_W = $clog2(NCPU + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr,
  input logic              rd,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irqL10,
  input logic [NCPU-1:0]   irqL14
);
  logic sysLim;
  assign sysLim = (int'(addr[ADDR_W-1:1]) == NCPU) && !addr[0];

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[FIELD_LSB-1:0] == '0);

  a_r3_sys_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqL10) |-> $past(tick));

  a_r8_cpu_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((irqL14 & ~$past(irqL14)) != '0) |-> $past(tick));

  a_r4_read_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && !tick && sysLim) |=> !irqL10);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irqL10 && !((rd || wr) && sysLim)) |=> irqL10);

  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sysLim) |=> !irqL10);

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rd) |-> rdata == '0);
endmodule

bind interval_timer_array interval_timer_array_chk #(
  .NCPU(NCPU), .DATA_W(DATA_W), .FIELD_LSB(FIELD_LSB)
) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr), .rd(rd), .addr(addr),
  .rdata(rdata), .irqL10(irqL10), .irqL14(irqL14)
);

// File: tb/test_interval_timer_array.sv
`timescale 1ns/1ps
module test_interval_timer_array;
  localparam int NCPU = 4;
  localparam int NT = NCPU + 1;
  localparam int DATA_W = 32;
  localparam int LSB = 10;
  localparam int CNT_W = DATA_W - LSB;
  localparam int ADDR_W = $clog2(NT) + 1;
  localparam int SYS = NCPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irqL10;
  logic [NCPU-1:0] irqL14;

  int total = 0;
  int bad = 0;

  logic [CNT_W-1:0] mCnt [NT];
  logic [CNT_W-1:0] mLim [NT];
  logic             mIrq [NT];

  always #5 clk = ~clk;

  interval_timer_array #(.NCPU(NCPU), .DATA_W(DATA_W), .FIELD_LSB(LSB)) i_interval_timer_array (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irqL10(irqL10), .irqL14(irqL14)
  );

  function automatic logic [ADDR_W-1:0] mkAddr(int slot, bit isCnt);
    return ADDR_W'((slot << 1) | int'(isCnt));
  endfunction

  function automatic logic [DATA_W-1:0] expRd(bit w, bit r, logic [ADDR_W-1:0] a);
    int s = int'(a[ADDR_W-1:1]);
    if (!r || w || s >= NT) return '0;
    if (a[0]) return {mCnt[s], {LSB{1'b0}}};
    return {mLim[s], {LSB{1'b0}}};
  endfunction

  function automatic logic [NT-1:0] expIrq();
    logic [NT-1:0] v;
    for (int k = 0; k < NT; k++) v[k] = mIrq[k];
    return v;
  endfunction

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelStep(bit tk, bit w, bit r, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    int s = int'(a[ADDR_W-1:1]);
    bit lim = !a[0] && s < NT;
    for (int k = 0; k < NT; k++) begin
      if (w && lim && s == k) begin
        mLim[k] = d[DATA_W-1:LSB];
        mCnt[k] = CNT_W'(1);
        mIrq[k] = 1'b0;
      end else begin
        bit hit = tk && mLim[k] != '0 && mCnt[k] == mLim[k];
        if (tk) mCnt[k] = hit ? CNT_W'(1) : mCnt[k] + 1'b1;
        if (hit) mIrq[k] = 1'b1;
        else if (r && !w && lim && s == k) mIrq[k] = 1'b0;
      end
    end
  endtask

  task automatic step(string req, bit tk, bit w, bit r, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    tick = tk; wr = w; rd = r; addr = a; wdata = d;
    #2;
    if (r) chk(req, rdata, expRd(w, r, a));
    modelStep(tk, w, r, a, d);
    @(posedge clk);
    #1;
    chk(req, DATA_W'({irqL10, irqL14}), DATA_W'(expIrq()));
  endtask

  task automatic idle(string req, bit tk);
    step(req, tk, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic rdReg(string req, int slot, bit isCnt, bit tk);
    step(req, tk, 1'b0, 1'b1, mkAddr(slot, isCnt), '0);
  endtask

  task automatic wrLim(string req, int slot, int val, bit tk);
    step(req, tk, 1'b1, 1'b0, mkAddr(slot, 1'b0), DATA_W'((val << LSB) | 32'h3ff));
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NT; k++) begin
      mCnt[k] = CNT_W'(1); mLim[k] = '0; mIrq[k] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq after reset", DATA_W'({irqL10, irqL14}), '0);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset values of every slot
    for (int s = 0; s < NT; s++) begin
      rdReg("R1 count", s, 1'b1, 1'b0);
      rdReg("R1 limit", s, 1'b0, 1'b0);
    end
    // R2: advance only on tick
    idle("R2", 1'b1); idle("R2", 1'b0); idle("R2", 1'b1); idle("R2", 1'b1);
    rdReg("R2 count field", SYS, 1'b1, 1'b0);
    rdReg("R2 count field", 0, 1'b1, 1'b0);
    // R3/R8: system period 3, cpu1 period 2
    wrLim("R3", SYS, 3, 1'b0);
    wrLim("R8", 1, 2, 1'b0);
    for (int i = 0; i < 3; i++) idle("R3 R8 hit", 1'b1);
    // R5: more hits while pending
    for (int i = 0; i < 5; i++) idle("R5 sticky", 1'b1);
    // R4: read acknowledges and returns the limit
    rdReg("R4 limit ack", SYS, 1'b0, 1'b0);
    rdReg("R4 limit ack", 1, 1'b0, 1'b0);
    idle("R4", 1'b0);
    // R10: read coincides with a hit
    wrLim("R10", 0, 2, 1'b0);
    idle("R10", 1'b1);
    rdReg("R10 hit wins", 0, 1'b0, 1'b1);
    idle("R10", 1'b0);
    // R6: write at the moment of a hit
    wrLim("R6", 3, 1, 1'b0);
    wrLim("R6 write over tick", 3, 4, 1'b1);
    rdReg("R6 count", 3, 1'b1, 1'b0);
    // R7: zero limit never fires
    wrLim("R7", 2, 0, 1'b0);
    for (int i = 0; i < 20; i++) idle("R7 no irq", 1'b1);
    rdReg("R7 count runs", 2, 1'b1, 1'b0);
    // R9: unused slots and count writes ignored
    wrLim("R9 bad slot", 6, 3, 1'b1);
    rdReg("R9 bad slot", 6, 1'b0, 1'b0);
    rdReg("R9 bad slot", 7, 1'b1, 1'b0);
    step("R9 count write", 1'b0, 1'b1, 1'b0, mkAddr(SYS, 1'b1), 32'hffff_fc00);
    rdReg("R9 count kept", SYS, 1'b1, 1'b0);
    // R11: write and read together
    step("R11 both", 1'b0, 1'b1, 1'b1, mkAddr(1, 1'b0), DATA_W'(5 << LSB));
    rdReg("R11 write done", 1, 1'b0, 1'b0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int op = int'($urandom % 10);
      bit tk = 1'($urandom % 2);
      logic [ADDR_W-1:0] a = ADDR_W'($urandom);
      logic [DATA_W-1:0] d = DATA_W'(((1 + $urandom % 5) << LSB) | ($urandom & 32'h3ff));
      if (op < 5)       step("R5 random", tk, 1'b0, 1'b0, a, d);
      else if (op < 7)  step("R6 random", tk, 1'b1, 1'b0, a, d);
      else if (op < 9)  step("R4 random", tk, 1'b0, 1'b1, a, d);
      else              step("R11 random", tk, 1'b1, 1'b1, a, d);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule